// File: doc/BRIEF.md
# Dimension-Sorting Input Flit Steering

This block sits at the input side of a router for a stacked-die mesh. It serves five input lanes (east, west, north, south and local injection). For each lane it sorts arriving flits into path sets by dimension: an east-west set, a north-south set, two vertical sets, or early ejection to the network interface. The decision is taken from the look-ahead route field carried in the header flit. That field names the output this router must use, so the steering is simple decoding, with no route computation here.

Each lane remembers the path set and the vertical virtual channel chosen for its open packet. Body and tail flits then follow their header whatever their own route bits hold. Vertical virtual channels are fixed by arrival direction, so two lanes never compete for one vertical queue. The local lane may use one or, optionally, two injection channels. A flit is taken only when its destination queue reports a free slot. A target-valid output pulses in the cycle a flit is taken. The flit itself is presented unchanged on the lane's output bus.

Top module: `steer_sort`

## Requirements
- R1: Flit bits [W-1:W-2] give the kind: 00 body, 01 head, 10 tail, 11 single (head and tail in one). Bits [W-3:W-5] are the route code. On a head or single flit, code 0 or 1 selects the east-west set, 2 or 3 the north-south set, 4 or 5 a vertical set, and 6 or 7 ejection.
- R2: Lanes are indexed 0 east, 1 west, 2 north, 3 south, 4 local. Vertical flits from lanes 0, 1 and 4 go to vertical set A, and those from lanes 2 and 3 go to set B.
- R3: A vertical flit from lanes 0 to 3 carries a virtual channel number equal to its lane index on `z_vc`.
- R4: A vertical header from the local lane takes channel 4 when channel 4 of set A has room. Otherwise, when the extra injection channel is enabled, it takes channel 5. If neither has room, the lane is not ready.
- R5: Body and tail flits go to the path set and channel recorded from their packet's header, and their own route code is ignored.
- R6: An accepted tail closes the lane's packet. A single flit never opens one. A body flit that follows either is treated as stray.
- R7: A flit is accepted (`in_ready` high) only when its destination reports space. A refused flit raises no target valid and does not change the lane's packet state.
- R8: A body or tail flit on a lane with no open packet is accepted and discarded, with no target valid raised.
- R9: `out_flit` carries each lane's input flit unchanged.
- R10: An accepted routed flit raises exactly one target valid for its lane. A lane that does not accept raises none.
- R11: After reset every lane has no open packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 5 | Flit present, one bit per lane |
| in_flit | input | 5*FLIT_W | Flits, lane i at bits [i*FLIT_W +: FLIT_W] |
| in_ready | output | 5 | Lane accepts its flit this cycle |
| out_flit | output | 5*FLIT_W | Flit copy toward the path sets |
| x_space | input | 5 | East-west set has room for lane i |
| x_valid | output | 5 | Push into east-west set |
| y_space | input | 5 | North-south set has room for lane i |
| y_valid | output | 5 | Push into north-south set |
| za_space | input | 5+EXTRA_INJ_VC | Per-channel room in vertical set A |
| zb_space | input | 5+EXTRA_INJ_VC | Per-channel room in vertical set B |
| za_valid | output | 5 | Push into vertical set A |
| zb_valid | output | 5 | Push into vertical set B |
| z_vc | output | 5*VCW | Vertical channel number per lane |
| ej_space | input | 5 | Ejection queue has room for lane i |
| ej_valid | output | 5 | Push into ejection queue |

## Verification
The hardest case to reach from the ports is a local packet that opened on injection channel 5 and must stay there. Its body and tail have to follow channel 5 after channel 4 frees up, while carrying route codes that would pick some other set. The stimulus holds channel 4's space low only for the header cycle, then raises it before the body and tail arrive. A second hard case is two lanes with packets open in different sets, fed flits in alternate cycles, while one lane's body stalls on a full channel between its neighbour's flits.

// File: rtl/steer_pkg.sv
// Package: shared types and constants of the dimension-sorting steering block.
// Assumes five input lanes in fixed order and a flit with kind and route bits on top.
package steer_pkg;

    localparam int NUM_LANE  = 5;
    localparam int LANE_E    = 0;
    localparam int LANE_W    = 1;
    localparam int LANE_N    = 2;
    localparam int LANE_S    = 3;
    localparam int LANE_L    = 4;
    localparam int INJ_BASE  = 4;   // first local-injection vertical channel

    localparam logic [1:0] K_BODY   = 2'b00;
    localparam logic [1:0] K_HEAD   = 2'b01;
    localparam logic [1:0] K_TAIL   = 2'b10;
    localparam logic [1:0] K_SINGLE = 2'b11;

    typedef enum logic [2:0] {
        PS_X    = 3'd0,
        PS_Y    = 3'd1,
        PS_ZA   = 3'd2,
        PS_ZB   = 3'd3,
        PS_EJ   = 3'd4,
        PS_DROP = 3'd5
    } pset_e;

endpackage

// File: rtl/steer_decode.sv
// Module: maps the look-ahead route code of a header to a path set.
// Assumes the lane index is fixed at elaboration; it picks the vertical set.
module steer_decode
    import steer_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [2:0] la,
    output pset_e      set
);

    localparam pset_e VSET = (LANE == LANE_N || LANE == LANE_S) ? PS_ZB : PS_ZA;

    // Route code to path set.
    always_comb begin
        unique case (la)
            3'd0, 3'd1: set = PS_X;
            3'd2, 3'd3: set = PS_Y;
            3'd4, 3'd5: set = VSET;
            default:    set = PS_EJ;
        endcase
    end

endmodule

// File: rtl/steer_lane.sv
// Module: steering for one input lane, with the packet lock and space gating.
// Assumes destinations report per-lane (planar, eject) or per-channel (vertical) room.
module steer_lane
    import steer_pkg::*;
#(
    parameter int LANE  = 0,
    parameter int EXTRA = 1,
    parameter int NZ    = 6,
    parameter int VCW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid,
    input  logic [1:0]     kind,
    input  logic [2:0]     la,
    input  logic           x_sp,
    input  logic           y_sp,
    input  logic           ej_sp,
    input  logic [NZ-1:0]  za_sp,
    input  logic [NZ-1:0]  zb_sp,
    output logic           ready,
    output logic           x_v,
    output logic           y_v,
    output logic           za_v,
    output logic           zb_v,
    output logic           ej_v,
    output logic [VCW-1:0] vc
);

    pset_e          dec_set;
    pset_e          cur_set;
    pset_e          set_q;
    logic           open_q;
    logic [VCW-1:0] vc_q;
    logic [VCW-1:0] head_vc;
    logic [VCW-1:0] cur_vc;
    logic           is_head;
    logic           sp_ok;
    logic           fire;

    steer_decode #(.LANE(LANE)) u_dec (
        .la  (la),
        .set (dec_set)
    );

    // Vertical channel for a new header: fixed per direction, chosen for local injection.
    generate
        if (LANE == LANE_L) begin : g_inj
            assign head_vc = za_sp[INJ_BASE] ? VCW'(INJ_BASE) : VCW'(INJ_BASE + EXTRA);
        end else begin : g_dir
            assign head_vc = VCW'(LANE);
        end
    endgenerate

    assign is_head = kind[0];
    assign cur_set = is_head ? dec_set : (open_q ? set_q : PS_DROP);
    assign cur_vc  = is_head ? head_vc : vc_q;

    // Room check at the chosen destination.
    always_comb begin
        unique case (cur_set)
            PS_X:    sp_ok = x_sp;
            PS_Y:    sp_ok = y_sp;
            PS_ZA:   sp_ok = za_sp[cur_vc];
            PS_ZB:   sp_ok = zb_sp[cur_vc];
            PS_EJ:   sp_ok = ej_sp;
            default: sp_ok = 1'b1;
        endcase
    end

    assign ready = sp_ok;
    assign fire  = valid & sp_ok;
    assign x_v   = fire & (cur_set == PS_X);
    assign y_v   = fire & (cur_set == PS_Y);
    assign za_v  = fire & (cur_set == PS_ZA);
    assign zb_v  = fire & (cur_set == PS_ZB);
    assign ej_v  = fire & (cur_set == PS_EJ);
    assign vc    = cur_vc;

    // Packet lock: opened by a head, closed by a tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            set_q  <= PS_DROP;
            vc_q   <= '0;
        end else if (fire) begin
            if (kind == K_HEAD) begin
                open_q <= 1'b1;
                set_q  <= dec_set;
                vc_q   <= head_vc;
            end else if (kind == K_TAIL) begin
                open_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/steer_sort.sv
// Module: top of the dimension-sorting steering block, five lanes side by side.
// Assumes lane order east, west, north, south, local; flits pass through unchanged.
module steer_sort
    import steer_pkg::*;
#(
    parameter int FLIT_W       = 32,
    parameter int EXTRA_INJ_VC = 1,
    localparam int NL  = NUM_LANE,
    localparam int NZ  = 5 + EXTRA_INJ_VC,
    localparam int VCW = $clog2(NZ)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NL-1:0]     in_valid,
    input  logic [NL*FLIT_W-1:0] in_flit,
    output logic [NL-1:0]     in_ready,
    output logic [NL*FLIT_W-1:0] out_flit,
    input  logic [NL-1:0]     x_space,
    output logic [NL-1:0]     x_valid,
    input  logic [NL-1:0]     y_space,
    output logic [NL-1:0]     y_valid,
    input  logic [NZ-1:0]     za_space,
    input  logic [NZ-1:0]     zb_space,
    output logic [NL-1:0]     za_valid,
    output logic [NL-1:0]     zb_valid,
    output logic [NL*VCW-1:0] z_vc,
    input  logic [NL-1:0]     ej_space,
    output logic [NL-1:0]     ej_valid
);

    // Flits leave unchanged toward every path set.
    assign out_flit = in_flit;

    genvar i;
    generate
        for (i = 0; i < NL; i++) begin : g_lane
            steer_lane #(
                .LANE  (i),
                .EXTRA (EXTRA_INJ_VC),
                .NZ    (NZ),
                .VCW   (VCW)
            ) u_lane (
                .clk   (clk),
                .rst_n (rst_n),
                .valid (in_valid[i]),
                .kind  (in_flit[i*FLIT_W + FLIT_W - 1 -: 2]),
                .la    (in_flit[i*FLIT_W + FLIT_W - 3 -: 3]),
                .x_sp  (x_space[i]),
                .y_sp  (y_space[i]),
                .ej_sp (ej_space[i]),
                .za_sp (za_space),
                .zb_sp (zb_space),
                .ready (in_ready[i]),
                .x_v   (x_valid[i]),
                .y_v   (y_valid[i]),
                .za_v  (za_valid[i]),
                .zb_v  (zb_valid[i]),
                .ej_v  (ej_valid[i]),
                .vc    (z_vc[i*VCW +: VCW])
            );
        end
    endgenerate

endmodule

// File: rtl/steer_sort_chk.sv
// Module: checker for steer_sort; tracks packets from the outputs on its own.
// Assumes it is attached by the bind statement at the end of this file.
module steer_sort_chk #(
    parameter int FLIT_W       = 32,
    parameter int EXTRA_INJ_VC = 1,
    localparam int NL  = 5,
    localparam int NZ  = 5 + EXTRA_INJ_VC,
    localparam int VCW = $clog2(NZ)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NL-1:0]     in_valid,
    input logic [NL*FLIT_W-1:0] in_flit,
    input logic [NL-1:0]     in_ready,
    input logic [NL*FLIT_W-1:0] out_flit,
    input logic [NL-1:0]     x_space,
    input logic [NL-1:0]     x_valid,
    input logic [NL-1:0]     y_space,
    input logic [NL-1:0]     y_valid,
    input logic [NZ-1:0]     za_space,
    input logic [NZ-1:0]     zb_space,
    input logic [NL-1:0]     za_valid,
    input logic [NL-1:0]     zb_valid,
    input logic [NL*VCW-1:0] z_vc,
    input logic [NL-1:0]     ej_space,
    input logic [NL-1:0]     ej_valid
);

    genvar i;
    generate
        for (i = 0; i < NL; i++) begin : g_chk
            logic           acc;
            logic [4:0]     t;
            logic [1:0]     kd;
            logic [VCW-1:0] vcl;
            logic           open_c;
            logic [4:0]     tgt_c;
            logic [VCW-1:0] vc_c;

            assign acc = in_valid[i] & in_ready[i];
            assign t   = {ej_valid[i], zb_valid[i], za_valid[i], y_valid[i], x_valid[i]};
            assign kd  = in_flit[i*FLIT_W + FLIT_W - 1 -: 2];
            assign vcl = z_vc[i*VCW +: VCW];

            // Independent record of each lane's open packet, built from the outputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    open_c <= 1'b0;
                    tgt_c  <= '0;
                    vc_c   <= '0;
                end else if (acc) begin
                    if (kd == 2'b01) begin
                        open_c <= 1'b1;
                        tgt_c  <= t;
                        vc_c   <= vcl;
                    end else if (kd == 2'b10) begin
                        open_c <= 1'b0;
                    end
                end
            end

            a_r10_one_target: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(t) <= 1)
                else $error("R10 lane %0d raised several targets", i);

            a_r10_push_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
                (|t) |-> (in_valid[i] && in_ready[i]))
                else $error("R10 lane %0d pushed without acceptance", i);

            a_r7_push_has_space: assert property (@(posedge clk) disable iff (!rst_n)
                (|t) |-> ((t[0] && x_space[i]) || (t[1] && y_space[i]) ||
                          (t[2] && za_space[vcl]) || (t[3] && zb_space[vcl]) ||
                          (t[4] && ej_space[i])))
                else $error("R7 lane %0d pushed into a full destination", i);

            a_r5_body_follows: assert property (@(posedge clk) disable iff (!rst_n)
                (acc && !kd[0] && open_c) |->
                    ((t == tgt_c) && (!(t[2] || t[3]) || (vcl == vc_c))))
                else $error("R5 lane %0d body left its packet path", i);

            a_r8_stray_dropped: assert property (@(posedge clk) disable iff (!rst_n)
                (acc && !kd[0] && !open_c) |-> (t == 5'b0))
                else $error("R8 lane %0d stray flit was forwarded", i);
        end
    endgenerate

endmodule

bind steer_sort steer_sort_chk #(
    .FLIT_W       (FLIT_W),
    .EXTRA_INJ_VC (EXTRA_INJ_VC)
) u_chk (.*);

// File: tb/sim_steer_sort.sv
// Bench: scoreboard for steer_sort. A driver task applies one flit per cycle and
// queues the expected outcome from its own packet model; a monitor compares.
module sim_steer_sort;

    localparam int CLK_P = 10;
    localparam int FW    = 32;
    localparam int NL    = 5;
    localparam int EXTRA = 1;
    localparam int NZ    = 5 + EXTRA;
    localparam int VCW   = $clog2(NZ);

    localparam int T_X = 0, T_Y = 1, T_ZA = 2, T_ZB = 3, T_EJ = 4, T_NONE = 5, T_MULTI = 6;
    localparam logic [1:0] BODY = 2'b00, HEAD = 2'b01, TAIL = 2'b10, SNGL = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     in_valid = '0;
    logic [NL*FW-1:0]  in_flit = '0;
    logic [NL-1:0]     in_ready;
    logic [NL*FW-1:0]  out_flit;
    logic [NL-1:0]     x_space = '1, y_space = '1, ej_space = '1;
    logic [NL-1:0]     x_valid, y_valid, za_valid, zb_valid, ej_valid;
    logic [NZ-1:0]     za_space = '1, zb_space = '1;
    logic [NL*VCW-1:0] z_vc;

    // Space values requested by the test; applied at the next drive.
    logic [NL-1:0] nx_x = '1, nx_y = '1, nx_ej = '1;
    logic [NZ-1:0] nx_za = '1, nx_zb = '1;

    int checks = 0;
    int fails  = 0;
    int seed   = 1;

    typedef struct {
        int          lane;
        int          tgt;
        int          vc;
        bit          rdy;
        logic [FW-1:0] flit;
        string       req;
    } exp_t;
    exp_t q[$];

    bit m_open[NL];
    int m_tgt[NL];
    int m_vc[NL];

    steer_sort #(.FLIT_W(FW), .EXTRA_INJ_VC(EXTRA)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .in_ready(in_ready), .out_flit(out_flit), .x_space(x_space), .x_valid(x_valid),
        .y_space(y_space), .y_valid(y_valid), .za_space(za_space), .zb_space(zb_space),
        .za_valid(za_valid), .zb_valid(zb_valid), .z_vc(z_vc), .ej_space(ej_space),
        .ej_valid(ej_valid)
    );

    always #(CLK_P/2) clk = ~clk;

    // Driver: apply one flit on one lane and queue its expected outcome.
    task automatic send(input int lane, input logic [1:0] kind, input logic [2:0] la,
                        input string req);
        exp_t e;
        logic [FW-1:0] f;
        int tg;
        int vc;
        bit sp;
        @(posedge clk); #1;
        x_space = nx_x; y_space = nx_y; ej_space = nx_ej; za_space = nx_za; zb_space = nx_zb;
        f = {kind, la, 27'(seed * 7919)};
        seed++;
        vc = 0;
        if (kind[0]) begin
            if (la <= 1) tg = T_X;
            else if (la <= 3) tg = T_Y;
            else if (la <= 5) tg = (lane == 2 || lane == 3) ? T_ZB : T_ZA;
            else tg = T_EJ;
            vc = (lane < 4) ? lane : (za_space[4] ? 4 : 5);
        end else if (m_open[lane]) begin
            tg = m_tgt[lane];
            vc = m_vc[lane];
        end else begin
            tg = T_NONE;
        end
        case (tg)
            T_X:  sp = x_space[lane];
            T_Y:  sp = y_space[lane];
            T_ZA: sp = za_space[vc];
            T_ZB: sp = zb_space[vc];
            T_EJ: sp = ej_space[lane];
            default: sp = 1'b1;
        endcase
        if (sp) begin
            if (kind == HEAD) begin
                m_open[lane] = 1'b1; m_tgt[lane] = tg; m_vc[lane] = vc;
            end else if (kind == TAIL) begin
                m_open[lane] = 1'b0;
            end
        end
        e.lane = lane; e.tgt = sp ? tg : T_NONE; e.vc = vc; e.rdy = sp; e.flit = f; e.req = req;
        in_valid = '0;
        in_valid[lane] = 1'b1;
        in_flit = '0;
        in_flit[lane*FW +: FW] = f;
        q.push_back(e);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = '0;
    endtask

    // Monitor: compare the queued expectation with the lane's outputs mid-cycle.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            int obs;
            int n;
            logic [4:0] v;
            logic [NL-1:0] others;
            e = q.pop_front();
            v = {ej_valid[e.lane], zb_valid[e.lane], za_valid[e.lane],
                 y_valid[e.lane], x_valid[e.lane]};
            n = $countones(v);
            obs = T_NONE;
            if (n > 1) obs = T_MULTI;
            else for (int k = 0; k < 5; k++) if (v[k]) obs = k;
            others = (x_valid | y_valid | za_valid | zb_valid | ej_valid);
            others[e.lane] = 1'b0;
            checks++;
            if (in_ready[e.lane] !== e.rdy) begin
                fails++;
                $display("FAIL %s lane %0d ready: got %0b expected %0b",
                         e.req, e.lane, in_ready[e.lane], e.rdy);
            end
            if (obs != e.tgt) begin
                fails++;
                $display("FAIL %s/R10 lane %0d target: got %0d expected %0d",
                         e.req, e.lane, obs, e.tgt);
            end
            if ((e.tgt == T_ZA || e.tgt == T_ZB) && int'(z_vc[e.lane*VCW +: VCW]) != e.vc) begin
                fails++;
                $display("FAIL %s lane %0d channel: got %0d expected %0d",
                         e.req, e.lane, z_vc[e.lane*VCW +: VCW], e.vc);
            end
            if (out_flit[e.lane*FW +: FW] !== e.flit) begin
                fails++;
                $display("FAIL R9 lane %0d flit: got %h expected %h",
                         e.lane, out_flit[e.lane*FW +: FW], e.flit);
            end
            if (others !== '0) begin
                fails++;
                $display("FAIL R10 idle lanes pushed: got %b expected 0", others);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_P * 50000);
        fails++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Test sequence.
    initial begin
        for (int k = 0; k < NL; k++) begin m_open[k] = 0; m_tgt[k] = T_NONE; m_vc[k] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 / R8: after reset a body flit is a stray and is dropped.
        send(0, BODY, 3'd0, "R11");
        send(3, TAIL, 3'd2, "R8");

        // R1: every route code on a single flit.
        for (int c = 0; c < 8; c++) send(0, SNGL, 3'(c), "R1");

        // R2 / R3: vertical set and channel by lane.
        for (int l = 0; l < 4; l++) send(l, SNGL, 3'd4, (l < 2) ? "R2" : "R3");
        send(4, SNGL, 3'd5, "R4");

        // R4 / R5: local packet on channel 5 stays there after channel 4 frees.
        nx_za[4] = 1'b0;
        send(4, HEAD, 3'd4, "R4");
        nx_za[4] = 1'b1;
        send(4, BODY, 3'd0, "R5");
        send(4, TAIL, 3'd2, "R5");
        send(4, BODY, 3'd4, "R6");

        // R4: both injection channels full stalls the local lane.
        nx_za[5:4] = 2'b00;
        send(4, SNGL, 3'd4, "R4");
        nx_za[5:4] = 2'b11;

        // R7: full planar set refuses the header and leaves the lane closed.
        nx_x[1] = 1'b0;
        send(1, HEAD, 3'd1, "R7");
        send(1, BODY, 3'd0, "R7");
        nx_x[1] = 1'b1;
        send(1, HEAD, 3'd1, "R7");
        send(1, TAIL, 3'd7, "R5");

        // R5: two lanes interleaved, one body stalls on a full vertical channel.
        send(2, HEAD, 3'd3, "R5");
        send(3, HEAD, 3'd5, "R3");
        send(2, BODY, 3'd6, "R5");
        nx_zb[3] = 1'b0;
        send(3, BODY, 3'd0, "R7");
        nx_zb[3] = 1'b1;
        send(3, BODY, 3'd0, "R5");
        send(2, TAIL, 3'd0, "R5");
        send(3, TAIL, 3'd1, "R5");

        // R6: a single flit opens nothing.
        send(0, SNGL, 3'd0, "R6");
        send(0, BODY, 3'd2, "R6");

        // R1 / R7: ejected packet with a stall on the ejection queue.
        send(1, HEAD, 3'd6, "R1");
        nx_ej[1] = 1'b0;
        send(1, BODY, 3'd0, "R7");
        nx_ej[1] = 1'b1;
        send(1, TAIL, 3'd3, "R5");

        idle();
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule